// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the digital serial port of a sigma-delta style converter. A host reaches it over four wires: an active-low select (`cs_n`), a serial clock (`sck`), serial data in (`sdi`) and serial data out (`sdo`), with `sdo_en` telling the pad when to drive. The converter core sits on the other side. It receives a one-cycle `conv_start` pulse, later returns a `conv_done` strobe with a 31-bit result, and takes the configuration word on `cfg_next` as the settings for the conversion it has just been told to start.

Only the host-clocked, single-cycle timing mode is built. While the select is low and no transfer is running, the data line shows whether a conversion is in progress, so the host can poll it or use it as an interrupt. The first rising clock with the converter asleep opens a 32-bit transfer. The status bit comes out first, then the held result from its most significant bit down. The configuration bits are captured as they arrive, and the 32nd falling clock starts the next conversion. If the clock is high when the select falls, the block records the internal-clock mode and opens no transfer. The pins are sampled in the `clk` domain and are assumed to be synchronised and much slower than `clk`.

Top module: `sio_readout`

## Requirements
- R1: `sdo_en` is 0 whenever `cs_n` is 1 and 1 whenever `cs_n` is 0. After reset, `conv_start` is 0 and `cfg_next` is all zeros.
- R2: With `cs_n` low and no transfer running, `sdo` is 1 while a conversion is in progress and 0 while the converter sleeps. Reset leaves it asleep.
- R3: `int_mode` takes the value of `sck` during reset and at every falling edge of `cs_n`. While it is 1, clock edges start no transfer, no conversion starts, and `sdo` keeps showing the status.
- R4: `conv_done` while a conversion is in progress stores `conv_result` and enters sleep. `conv_done` while asleep is ignored, and the stored result is unchanged.
- R5: A transfer starts at the first rising `sck` edge seen with `cs_n` low, the converter asleep and `int_mode` 0. Bit k of the 32-bit frame (k=0 first) appears on `sdo` after the k-th falling edge. Bit 0 is the status bit, which is 0, and bits 1..31 are `conv_result[30]` down to `conv_result[0]`.
- R6: `sdi` is sampled on rising `sck` edges of a transfer, first edge included. The first 8 bits form the configuration, first bit as MSB. `cfg_next` takes this value only when that transfer's conversion starts, and holds it otherwise.
- R7: On the 32nd falling `sck` edge, `conv_start` pulses for exactly one `clk` cycle, the converter becomes busy, and `sdo` shows 1.
- R8: If `cs_n` rises before the 32nd falling edge, the transfer is dropped. No conversion starts, the stored result is kept, and the next transfer starts again from the status bit.
- R9: If `cs_n` stays low after a transfer, `sdo` falls from 1 to 0 when the conversion completes, acting as an end-of-conversion interrupt.
- R10: While a conversion is in progress, `sck` edges with `cs_n` low start no transfer and leave `cfg_next` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low (synchronised) |
| sck | input | 1 | Host serial clock (synchronised) |
| sdi | input | 1 | Serial configuration input |
| sdo | output | 1 | Serial data / status output |
| sdo_en | output | 1 | Output driver enable; 0 means high impedance |
| conv_done | input | 1 | One-cycle strobe from the core: conversion finished |
| conv_result | input | 31 | Result from the core, valid with `conv_done` |
| conv_start | output | 1 | One-cycle pulse: start the next conversion |
| cfg_next | output | 8 | Configuration for the conversion just started |
| int_mode | output | 1 | Internal-clock mode was selected at the last select fall |

## Verification
The assertions assume that the core never raises `conv_done` in the cycle right after `conv_start`, and that `sck` and `cs_n` never change in the same `clk` cycle. The bench stimulus respects both: each select change is separated from clock edges by several `clk` cycles, and the emulated core answers a start only after a wait of several cycles. Every pin level is held for three `clk` cycles, so each edge is seen once.

// File: rtl/sio_pkg.sv
// Shared types for the converter serial readout port.
package sio_pkg;

    // Pin events seen in one clk cycle.
    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_fall;
    } sio_evt_t;

endpackage

// File: rtl/sio_edge_det.sv
// Edge detector for the serial pins.
// Assumes cs_n and sck are already synchronised to clk and hold each level
// for at least one clk cycle. Emits one-cycle event flags.
module sio_edge_det
    import sio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     sck,
    output sio_evt_t evt
);

    logic sck_q;
    logic cs_q;

    // Keep the previous pin levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Compare current and previous levels.
    always_comb begin
        evt.sck_rise = sck & ~sck_q;
        evt.sck_fall = ~sck & sck_q;
        evt.cs_fall  = cs_q & ~cs_n;
    end

endmodule

// File: rtl/sio_ctrl.sv
// Sequencer for the serial port. It tracks conversion busy/sleep, the
// timing mode, and whether a transfer is open. It counts rising and falling
// clock edges inside a transfer.
// Assumes the core strobes conv_done only after a conv_start.
module sio_ctrl
    import sio_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int CFG_W   = 8,
    localparam int IDX_W  = $clog2(FRAME_W),
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  sio_evt_t         evt,
    input  logic             conv_done,
    output logic             busy,
    output logic             active,
    output logic             int_mode,
    output logic             conv_start,
    output logic [IDX_W-1:0] fall_idx,
    output logic             res_load,
    output logic             cfg_shift,
    output logic             cfg_load
);

    logic             mode_now;
    logic             start;
    logic             rise_take;
    logic             fall_take;
    logic             last_fall;
    logic [CNT_W-1:0] rise_cnt;
    logic [CNT_W-1:0] rise_idx;

    // Decode which pin events act on the transfer in this cycle.
    always_comb begin
        mode_now  = evt.cs_fall ? sck : int_mode;
        start     = evt.sck_rise && !cs_n && !active && !busy && !mode_now;
        rise_take = evt.sck_rise && !cs_n && (active || start);
        fall_take = evt.sck_fall && !cs_n && active;
        last_fall = fall_take && (fall_idx == IDX_W'(FRAME_W - 1));
        rise_idx  = start ? '0 : rise_cnt;
        cfg_shift = rise_take && (rise_idx < CNT_W'(CFG_W));
        cfg_load  = last_fall;
        res_load  = conv_done && busy;
    end

    // Keep the mode, busy, and transfer state, and issue the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_mode   <= sck;
            busy       <= 1'b0;
            active     <= 1'b0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= last_fall;
            if (evt.cs_fall) int_mode <= sck;
            if (last_fall)      busy <= 1'b1;
            else if (conv_done) busy <= 1'b0;
            if (cs_n)           active <= 1'b0;
            else if (start)     active <= 1'b1;
            else if (last_fall) active <= 1'b0;
        end
    end

    // Count the edges inside a transfer. Raising the select clears the counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_idx <= '0;
            rise_cnt <= '0;
        end else begin
            if (cs_n || start || last_fall) fall_idx <= '0;
            else if (fall_take)             fall_idx <= fall_idx + 1'b1;
            if (cs_n)
                rise_cnt <= '0;
            else if (rise_take && rise_idx != CNT_W'(FRAME_W))
                rise_cnt <= rise_idx + 1'b1;
        end
    end

endmodule

// File: rtl/sio_data.sv
// Data path of the serial port. It holds the result statically, picks the
// frame bit for sdo without disturbing the held word, collects configuration
// bits, and publishes them when a conversion starts. Assumes CFG_W >= 2.
module sio_data #(
    parameter int FRAME_W = 32,
    parameter int CFG_W   = 8,
    localparam int IDX_W  = $clog2(FRAME_W),
    localparam int RES_W  = FRAME_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdi,
    input  logic [RES_W-1:0] res_in,
    input  logic             res_load,
    input  logic             cfg_shift,
    input  logic             cfg_load,
    input  logic             active,
    input  logic             busy,
    input  logic [IDX_W-1:0] fall_idx,
    output logic             sdo,
    output logic [CFG_W-1:0] cfg_next
);

    logic [RES_W-1:0]   res_q;
    logic [CFG_W-1:0]   cfg_sh;
    logic [FRAME_W-1:0] frame;
    logic [IDX_W-1:0]   bit_sel;

    // Store the finished result and collect the incoming configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q    <= '0;
            cfg_sh   <= '0;
            cfg_next <= '0;
        end else begin
            if (res_load)  res_q    <= res_in;
            if (cfg_shift) cfg_sh   <= {cfg_sh[CFG_W-2:0], sdi};
            if (cfg_load)  cfg_next <= cfg_sh;
        end
    end

    // Drive the status, or the frame bit chosen by the fall count.
    always_comb begin
        frame   = {1'b0, res_q};
        bit_sel = IDX_W'(FRAME_W - 1) - fall_idx;
        sdo     = active ? frame[bit_sel] : busy;
    end

endmodule

// File: rtl/sio_readout.sv
// Top of the converter serial readout port (host-clocked single-cycle mode).
// Assumes the pins are synchronised to clk and much slower than clk.
// When sdo_en is low, the pad must release sdo.
module sio_readout #(
    parameter int FRAME_W = 32,
    parameter int CFG_W   = 8,
    localparam int RES_W  = FRAME_W - 1,
    localparam int IDX_W  = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             sdi,
    output logic             sdo,
    output logic             sdo_en,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             conv_start,
    output logic [CFG_W-1:0] cfg_next,
    output logic             int_mode
);

    sio_pkg::sio_evt_t evt;
    logic             busy;
    logic             active;
    logic [IDX_W-1:0] fall_idx;
    logic             res_load;
    logic             cfg_shift;
    logic             cfg_load;

    sio_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sck   (sck),
        .evt   (evt)
    );

    sio_ctrl #(.FRAME_W(FRAME_W), .CFG_W(CFG_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck        (sck),
        .evt        (evt),
        .conv_done  (conv_done),
        .busy       (busy),
        .active     (active),
        .int_mode   (int_mode),
        .conv_start (conv_start),
        .fall_idx   (fall_idx),
        .res_load   (res_load),
        .cfg_shift  (cfg_shift),
        .cfg_load   (cfg_load)
    );

    sio_data #(.FRAME_W(FRAME_W), .CFG_W(CFG_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdi       (sdi),
        .res_in    (conv_result),
        .res_load  (res_load),
        .cfg_shift (cfg_shift),
        .cfg_load  (cfg_load),
        .active    (active),
        .busy      (busy),
        .fall_idx  (fall_idx),
        .sdo       (sdo),
        .cfg_next  (cfg_next)
    );

    // The output driver is on only while the port is selected.
    always_comb sdo_en = ~cs_n;

endmodule

// File: rtl/sio_checker.sv
// Protocol checks for sio_readout, attached with bind.
// Assumes conv_done never arrives in the cycle right after conv_start.
module sio_checker #(
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sdo,
    input logic             sdo_en,
    input logic             conv_start,
    input logic [CFG_W-1:0] cfg_next,
    input logic             int_mode
);

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R7

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> sdo); // R7

    AST_START_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(!cs_n)); // R8

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |-> $stable(cfg_next)); // R6

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> $stable(int_mode)); // R3

    AST_NO_START_INTMODE: assert property (@(posedge clk) disable iff (!rst_n)
        int_mode |-> !conv_start); // R3

    AST_DRIVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !sdo_en); // R1

endmodule

bind sio_readout sio_checker #(.CFG_W(CFG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sdo        (sdo),
    .sdo_en     (sdo_en),
    .conv_start (conv_start),
    .cfg_next   (cfg_next),
    .int_mode   (int_mode)
);

// File: tb/sio_readout_tb.sv
// Bench for sio_readout: a behavioural model is compared every clock, and
// directed checks cover the corner cases.
module sio_readout_tb;

    localparam int FW   = 32;
    localparam int CW   = 8;
    localparam int HALF = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_n;
    logic          sck;
    logic          sdi;
    logic          sdo;
    logic          sdo_en;
    logic          conv_done;
    logic [FW-2:0] conv_result;
    logic          conv_start;
    logic [CW-1:0] cfg_next;
    logic          int_mode;

    int errors = 0;
    int checks = 0;
    int starts = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    sio_readout u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sck         (sck),
        .sdi         (sdi),
        .sdo         (sdo),
        .sdo_en      (sdo_en),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .conv_start  (conv_start),
        .cfg_next    (cfg_next),
        .int_mode    (int_mode)
    );

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model
    bit            q[$];
    bit            m_busy, m_active, m_int, m_start, p_sck, p_cs;
    logic [FW-2:0] m_res;
    logic [CW-1:0] m_cfg, m_sh;
    int            m_nr;
    bit            m_live;

    always @(posedge clk) begin
        bit rise, fall, csf, old_busy;
        if (!rst_n) begin
            m_busy = 0; m_active = 0; m_res = '0; m_cfg = '0; m_sh = '0;
            m_nr = 0; m_int = sck; m_start = 0; p_sck = 0; p_cs = 1; q.delete();
            m_live = 1;
        end else begin
            rise = sck && !p_sck;
            fall = !sck && p_sck;
            csf  = p_cs && !cs_n;
            old_busy = m_busy;
            m_start = 0;
            if (csf) m_int = sck;
            if (conv_done && m_busy) begin m_busy = 0; m_res = conv_result; end
            if (cs_n) begin
                m_active = 0;
            end else begin
                if (rise && !m_active && !old_busy && !m_int) begin
                    m_active = 1; m_nr = 0; q.delete();
                    q.push_back(1'b0);
                    for (int i = FW - 2; i >= 0; i--) q.push_back(m_res[i]);
                end
                if (rise && m_active) begin
                    if (m_nr < CW) m_sh = {m_sh[CW-2:0], sdi};
                    m_nr++;
                end else if (fall && m_active) begin
                    if (q.size() == 1) begin
                        m_active = 0; m_busy = 1; m_start = 1; m_cfg = m_sh; q.delete();
                    end else begin
                        void'(q.pop_front());
                    end
                end
            end
            p_sck = sck;
            p_cs  = cs_n;
        end
    end

    // Compare against the model every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && m_live) begin
            check(sdo_en == !cs_n, "R1 driver enable", sdo_en, !cs_n);
            if (!cs_n)
                check(sdo == (m_active ? q[0] : m_busy), "R2/R5 sdo level", sdo,
                      m_active ? q[0] : m_busy);
            check(conv_start == m_start, "R7 start pulse", conv_start, m_start);
            check(cfg_next == m_cfg, "R6 cfg_next", cfg_next, m_cfg);
            check(int_mode == m_int, "R3 mode flag", int_mode, m_int);
            if (conv_start) starts++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++; checks++;
            $display("FAIL watchdog all R actual=%0d expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_cycle(input logic din, output logic dout);
        sdi = din;
        wait_clk(HALF);
        dout = sdo;
        sck = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
    endtask

    task automatic read_frame(input logic [CW-1:0] cfg, output logic [FW-1:0] w);
        logic b;
        for (int i = 0; i < FW; i++) begin
            sck_cycle(i < CW ? cfg[CW-1-i] : 1'b0, b);
            w[FW-1-i] = b;
        end
        wait_clk(HALF);
    endtask

    task automatic core_done(input logic [FW-2:0] val);
        @(negedge clk);
        conv_result = val;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        wait_clk(2);
    endtask

    initial begin
        logic [FW-1:0] w;
        logic          b;
        int            s0;
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
        conv_done = 1'b0; conv_result = '0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(1);
        // R1: reset state
        check(sdo_en == 1'b0, "R1 reset enable", sdo_en, 0);
        check(conv_start == 1'b0, "R1 reset start", conv_start, 0);
        check(cfg_next == '0, "R1 reset cfg", cfg_next, 0);
        check(int_mode == 1'b0, "R3 reset mode", int_mode, 0);

        // R2: asleep after reset
        cs_n = 1'b0;
        wait_clk(3);
        check(sdo_en == 1'b1, "R1 enable on select", sdo_en, 1);
        check(sdo == 1'b0, "R2 asleep status", sdo, 0);

        // R5 R6 R7: first frame
        read_frame(8'hA5, w);
        check(w == '0, "R5 frame after reset", w, 0);
        check(starts == 1, "R7 one start", starts, 1);
        check(cfg_next == 8'hA5, "R6 cfg applied", cfg_next, 8'hA5);
        check(sdo == 1'b1, "R7 busy shown", sdo, 1);

        // R10: clocks while busy
        s0 = starts;
        for (int i = 0; i < 8; i++) sck_cycle(1'b1, b);
        wait_clk(HALF);
        check(starts == s0, "R10 no start while busy", starts, s0);
        check(cfg_next == 8'hA5, "R10 cfg kept", cfg_next, 8'hA5);
        check(sdo == 1'b1, "R10 still busy", sdo, 1);

        // R9: interrupt on completion, select held low
        core_done(31'h5A5A_1234);
        check(sdo == 1'b0, "R9 done falls", sdo, 0);

        // R5: result frame
        read_frame(8'h3C, w);
        check(w == {1'b0, 31'h5A5A_1234}, "R5 result frame", w, {1'b0, 31'h5A5A_1234});
        check(cfg_next == 8'h3C, "R6 second cfg", cfg_next, 8'h3C);

        // R8: aborted transfer keeps the result
        core_done(31'h1234_5678);
        cs_n = 1'b1; wait_clk(3); cs_n = 1'b0; wait_clk(3);
        s0 = starts;
        for (int i = 0; i < 10; i++) sck_cycle(1'b0, b);
        wait_clk(2);
        cs_n = 1'b1; wait_clk(4);
        check(sdo_en == 1'b0, "R1 released", sdo_en, 0);
        check(starts == s0, "R8 no start on abort", starts, s0);
        check(cfg_next == 8'h3C, "R8 cfg kept", cfg_next, 8'h3C);
        cs_n = 1'b0; wait_clk(3);
        check(sdo == 1'b0, "R8 still asleep", sdo, 0);
        read_frame(8'hFF, w);
        check(w == {1'b0, 31'h1234_5678}, "R8 full frame after abort", w, {1'b0, 31'h1234_5678});
        check(starts == s0 + 1, "R8 start after full frame", starts, s0 + 1);

        // R4: completion strobe while asleep is ignored
        core_done(31'h0F0F_0F0F);
        core_done(31'h7FFF_FFFF);
        read_frame(8'h81, w);
        check(w == {1'b0, 31'h0F0F_0F0F}, "R4 idle strobe ignored", w, {1'b0, 31'h0F0F_0F0F});
        check(cfg_next == 8'h81, "R6 third cfg", cfg_next, 8'h81);

        // R3: internal-clock mode selected by sck high at select fall
        core_done(31'h0000_00FF);
        cs_n = 1'b1; wait_clk(3); sck = 1'b1; wait_clk(3); cs_n = 1'b0; wait_clk(3);
        check(int_mode == 1'b1, "R3 internal mode flagged", int_mode, 1);
        s0 = starts;
        sck = 1'b0; wait_clk(HALF);
        for (int i = 0; i < 40; i++) sck_cycle(1'b1, b);
        wait_clk(HALF);
        check(starts == s0, "R3 no start in internal mode", starts, s0);
        check(sdo == 1'b0, "R3 status kept", sdo, 0);
        cs_n = 1'b1; wait_clk(3); cs_n = 1'b0; wait_clk(3);
        check(int_mode == 1'b0, "R3 back to external", int_mode, 0);
        read_frame(8'h42, w);
        check(w == {1'b0, 31'h0000_00FF}, "R5 frame after mode switch", w, {1'b0, 31'h0000_00FF});
        cs_n = 1'b1;
        wait_clk(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule